// File: doc/BRIEF.md
# Eight-Bit GPIO Port With Pin Takeover Resolution

This block manages an eight-pin general-purpose I/O port. Software sets a direction mask, an output latch and an analog-select mask through a small register interface, and reads back either those registers or the sampled pin levels. For each pin the block decides three things: whether the pad driver is enabled, which value it drives, and whether the digital input buffer is on. Pins with no drive enabled are tri-stated. Output enable and output data are separate signals for each pin.

Other functions can take a pin over. Two comparator outputs can replace latch data on pins 4 and 5. A reference-voltage output can claim pin 2 completely. The oscillator mode decides whether pins 6 and 7 are free for port use, whether pin 6 carries a divided-by-four clock, or whether the oscillator owns those pins. An analog selection turns off a pin's digital input but leaves its latch-driven output alone. Pin levels pass through a two-flop synchronizer before software can read them. Pin 4 also supplies a synchronized clock input to a timer.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the direction register reads 0xFF (all inputs), the latch reads 0x00 and the analog mask reads 0x2F. Bits 0, 1, 2, 3 and 5 are analog and bit 4 is digital, so every `pin_oe` is 0 and `pin_ie` is 0xD0 while `osc_mode` is 0.
- R2: A pin whose direction bit is 0 and that has no takeover drives `pin_oe`=1 and `pin_out` equal to its latch bit. Writes to register address 1 or address 2 both update the latch.
- R3: A pin whose direction bit is 1 has `pin_oe`=0. The port read (address 2) shows its input level two clock edges after the level changes, and not after one edge.
- R4: A pin with its analog-mask bit set has `pin_ie`=0 and reads 0 through the port register. If its direction bit is 0 it still drives its latch bit.
- R5: When `cmp1_oe` is 1 and direction bit 4 is 0, pin 4 drives `cmp1_val` in place of the latch. `cmp2_oe` and `cmp2_val` do the same for pin 5. With the direction bit at 1 the pin is not driven.
- R6: When `vref_oe` is 1, pin 2 has `pin_oe`=0 and `pin_ie`=0 whatever its direction bit is.
- R7: `osc_mode` encodes the pin ownership. 0 leaves pins 6 and 7 free. 1 puts the clock on pin 6 and leaves pin 7 free. 2 gives pin 7 to the oscillator. 3 gives both pins to the oscillator. An owned pin has `pin_oe`=0 and `pin_ie`=0 and reads 0.
- R8: With `osc_mode`=1, pin 6 has `pin_oe`=1 and `pin_ie`=0 regardless of its direction bit. It drives a square wave with a period of four clock cycles: each level lasts two cycles.
- R9: `tmr_clk` follows the synchronized level of pin 4 and is forced to 0 while pin 4's input buffer is off.
- R10: Register addresses are 0 for direction, 1 for latch, 2 for port and 3 for analog mask. A latch read returns the last value written. Address 3 is writable and readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| cmp1_oe | input | 1 | Route comparator 1 to pin 4 |
| cmp1_val | input | 1 | Comparator 1 output level |
| cmp2_oe | input | 1 | Route comparator 2 to pin 5 |
| cmp2_val | input | 1 | Comparator 2 output level |
| vref_oe | input | 1 | Reference output claims pin 2 |
| osc_mode | input | 2 | Oscillator pin-ownership mode |
| pin_in | input | 8 | Pad input levels |
| pin_oe | output | 8 | Pad driver enable per pin |
| pin_out | output | 8 | Pad output data per pin |
| pin_ie | output | 8 | Digital input buffer enable per pin |
| tmr_clk | output | 1 | Synchronized timer clock from pin 4 |

## Verification
The assertions run on every cycle. They check that an analog-marked pin always reads 0 through the port. They check that the reference output and crystal mode always silence their pins. They check that a comparator always wins over the latch on an output pin, and that a direction write reaches the driver one cycle later. Some behaviour only the bench's scenarios can show: the reset values of the registers, the exact two-edge synchronizer latency, the four-cycle period of the clock output, and the complete per-pin output and input-enable patterns under mixed configurations.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    OSC_PINS_FREE = 2'd0,
    OSC_CLK_OUT   = 2'd1,
    OSC_EXT_IN    = 2'd2,
    OSC_CRYSTAL   = 2'd3
  } osc_mode_e;

  typedef enum logic [1:0] {
    REG_DIR  = 2'd0,
    REG_LAT  = 2'd1,
    REG_PORT = 2'd2,
    REG_ANA  = 2'd3
  } reg_sel_e;

  // oscillator owns the upper output-side pin
  function automatic logic osc_owns_out_pin(osc_mode_e m);
    return (m == OSC_CRYSTAL);
  endfunction

  // oscillator owns the upper input-side pin
  function automatic logic osc_owns_in_pin(osc_mode_e m);
    return (m == OSC_CRYSTAL) || (m == OSC_EXT_IN);
  endfunction

  // divided clock replaces port data on the output-side pin
  function automatic logic osc_drives_clk(osc_mode_e m);
    return (m == OSC_CLK_OUT);
  endfunction

  // final port read value: synchronized level gated by input enable
  function automatic logic [7:0] gate_input(logic [7:0] lvl, logic [7:0] ie);
    return lvl & ie;
  endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int              WIDTH   = 8,
  parameter logic [WIDTH-1:0] ANA_RST = 8'h2F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] lat_q,
  output logic [WIDTH-1:0] ana_q
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(wr_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      lat_q <= '0;
      ana_q <= ANA_RST;
    end else if (wr_en) begin
      unique case (sel)
        REG_DIR:          dir_q <= wr_data;
        REG_LAT, REG_PORT: lat_q <= wr_data;
        REG_ANA:          ana_q <= wr_data;
        default:          ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_pin_resolve.sv
module gpio_pin_resolve (
  input  logic dir,
  input  logic lat,
  input  logic ana,
  input  logic alt_en,
  input  logic alt_val,
  input  logic kill,
  input  logic clk_en,
  input  logic clk_val,
  output logic oe,
  output logic dout,
  output logic ie
);
  // priority: full takeover > clock drive > peripheral data > latch
  always_comb begin
    if (kill) begin
      oe   = 1'b0;
      dout = lat;
      ie   = 1'b0;
    end else if (clk_en) begin
      oe   = 1'b1;
      dout = clk_val;
      ie   = 1'b0;
    end else begin
      oe   = ~dir;
      dout = alt_en ? alt_val : lat;
      ie   = ~ana;
    end
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int VREF_PIN = 2,
  parameter int CMP1_PIN = 4,
  parameter int CMP2_PIN = 5,
  parameter int OSC_OPIN = 6,
  parameter int OSC_IPIN = 7,
  parameter int TMR_PIN  = 4,
  parameter logic [WIDTH-1:0] ANA_RST = 8'h2F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [WIDTH-1:0] rd_data,
  input  logic             cmp1_oe,
  input  logic             cmp1_val,
  input  logic             cmp2_oe,
  input  logic             cmp2_val,
  input  logic             vref_oe,
  input  logic [1:0]       osc_mode,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_ie,
  output logic             tmr_clk
);
  localparam int DIV_BITS = 2;

  osc_mode_e osc_m;
  reg_sel_e  rsel;
  assign osc_m = osc_mode_e'(osc_mode);
  assign rsel  = reg_sel_e'(rd_addr);

  logic [WIDTH-1:0] dir_q, lat_q, ana_q;
  logic [WIDTH-1:0] sync_lvl, port_val;
  // named per-pin takeover events for the checker
  logic [WIDTH-1:0] pin_kill, pin_alt_en, pin_alt_val, pin_clk_en;
  logic [DIV_BITS-1:0] div_cnt;
  logic             clk_q4;

  gpio_port_regs #(.WIDTH(WIDTH), .ANA_RST(ANA_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .dir_q(dir_q), .lat_q(lat_q), .ana_q(ana_q)
  );

  gpio_sync2 #(.WIDTH(WIDTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= div_cnt + 1'b1;
  end
  assign clk_q4 = div_cnt[DIV_BITS-1];

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    always_comb begin
      pin_kill[i]    = 1'b0;
      pin_alt_en[i]  = 1'b0;
      pin_alt_val[i] = 1'b0;
      pin_clk_en[i]  = 1'b0;
      if (i == VREF_PIN) pin_kill[i] = vref_oe;
      if (i == OSC_OPIN) begin
        pin_kill[i]   = osc_owns_out_pin(osc_m);
        pin_clk_en[i] = osc_drives_clk(osc_m);
      end
      if (i == OSC_IPIN) pin_kill[i] = osc_owns_in_pin(osc_m);
      if (i == CMP1_PIN) begin
        pin_alt_en[i]  = cmp1_oe;
        pin_alt_val[i] = cmp1_val;
      end
      if (i == CMP2_PIN) begin
        pin_alt_en[i]  = cmp2_oe;
        pin_alt_val[i] = cmp2_val;
      end
    end

    gpio_pin_resolve u_res (
      .dir(dir_q[i]), .lat(lat_q[i]), .ana(ana_q[i]),
      .alt_en(pin_alt_en[i]), .alt_val(pin_alt_val[i]),
      .kill(pin_kill[i]), .clk_en(pin_clk_en[i]), .clk_val(clk_q4),
      .oe(pin_oe[i]), .dout(pin_out[i]), .ie(pin_ie[i])
    );
  end

  assign port_val = gate_input(sync_lvl, pin_ie);
  assign tmr_clk  = port_val[TMR_PIN];

  always_comb begin
    unique case (rsel)
      REG_DIR:  rd_data = dir_q;
      REG_LAT:  rd_data = lat_q;
      REG_PORT: rd_data = port_val;
      REG_ANA:  rd_data = ana_q;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int WIDTH    = 8,
  parameter int VREF_PIN = 2,
  parameter int CMP1_PIN = 4,
  parameter int OSC_OPIN = 6,
  parameter int OSC_IPIN = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [WIDTH-1:0] wr_data,
  input logic [1:0]       rd_addr,
  input logic [WIDTH-1:0] rd_data,
  input logic             cmp1_oe,
  input logic             cmp1_val,
  input logic             vref_oe,
  input logic [1:0]       osc_mode,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] ana_q,
  input logic [WIDTH-1:0] pin_oe,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_ie
);
  // direction write reaches bit 0 driver on the next cycle
  assert_dir_to_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0) |=> (pin_oe[0] == !$past(wr_data[0])));

  assert_dir_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0 && wr_data[1]) |=> !pin_oe[1]);

  // analog pins read zero on the port register
  assert_analog_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd2) |-> ((rd_data & ana_q) == '0));

  assert_analog_no_ie_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_ie & ana_q) == '0));

  assert_cmp_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp1_oe && !dir_q[CMP1_PIN]) |-> (pin_oe[CMP1_PIN] && pin_out[CMP1_PIN] == cmp1_val));

  assert_vref_silences_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vref_oe |-> (!pin_oe[VREF_PIN] && !pin_ie[VREF_PIN]));

  assert_crystal_owns_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_mode == 2'd3) |-> (!pin_oe[OSC_OPIN] && !pin_oe[OSC_IPIN]
                            && !pin_ie[OSC_OPIN] && !pin_ie[OSC_IPIN]));

  assert_clkout_drives_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_mode == 2'd1) |-> (pin_oe[OSC_OPIN] && !pin_ie[OSC_OPIN]));

  assert_clkout_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_mode == 2'd1 && $past(osc_mode == 2'd1) && $past(rst_n, 2)
     && $past(osc_mode == 2'd1, 2))
    |-> (pin_out[OSC_OPIN] != $past(pin_out[OSC_OPIN], 2)));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(
  .WIDTH(WIDTH), .VREF_PIN(VREF_PIN), .CMP1_PIN(CMP1_PIN),
  .OSC_OPIN(OSC_OPIN), .OSC_IPIN(OSC_IPIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
  .cmp1_oe(cmp1_oe), .cmp1_val(cmp1_val), .vref_oe(vref_oe),
  .osc_mode(osc_mode), .dir_q(dir_q), .ana_q(ana_q),
  .pin_oe(pin_oe), .pin_out(pin_out), .pin_ie(pin_ie)
);

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       cmp1_oe = 0, cmp1_val = 0, cmp2_oe = 0, cmp2_val = 0, vref_oe = 0;
  logic [1:0] osc_mode = '0;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_oe, pin_out, pin_ie;
  logic       tmr_clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_port_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cmp1_oe(cmp1_oe), .cmp1_val(cmp1_val), .cmp2_oe(cmp2_oe),
    .cmp2_val(cmp2_val), .vref_oe(vref_oe), .osc_mode(osc_mode),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
    .pin_ie(pin_ie), .tmr_clk(tmr_clk)
  );

  // vector: dir, lat, ana, {c1oe,c1v,c2oe,c2v,vref}, osc, pin, exp_oe, exp_out, exp_ie, exp_port
  typedef struct packed {
    logic [7:0] dir;
    logic [7:0] lat;
    logic [7:0] ana;
    logic [4:0] cfg;
    logic [1:0] osc;
    logic [7:0] pin;
    logic [7:0] e_oe;
    logic [7:0] e_out;
    logic [7:0] e_ie;
    logic [7:0] e_port;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 8'hA5, 8'h00, 5'b00000, 2'd0, 8'h00, 8'hFF, 8'hA5, 8'hFF, 8'h00}, // R2
    '{8'hFF, 8'hA5, 8'h00, 5'b00000, 2'd0, 8'h3C, 8'h00, 8'h00, 8'hFF, 8'h3C}, // R3
    '{8'h00, 8'hFF, 8'h2F, 5'b00000, 2'd0, 8'hFF, 8'hFF, 8'hFF, 8'hD0, 8'hD0}, // R4
    '{8'h00, 8'h20, 8'h00, 5'b11100, 2'd0, 8'h00, 8'hFF, 8'h10, 8'hFF, 8'h00}, // R5
    '{8'h30, 8'h00, 8'h00, 5'b11110, 2'd0, 8'h30, 8'hCF, 8'h00, 8'hFF, 8'h30}, // R5
    '{8'h00, 8'hFF, 8'h00, 5'b00001, 2'd0, 8'hFF, 8'hFB, 8'hFF, 8'hFB, 8'hFB}, // R6
    '{8'h00, 8'hFF, 8'h00, 5'b00000, 2'd3, 8'hFF, 8'h3F, 8'hFF, 8'h3F, 8'h3F}, // R7
    '{8'h00, 8'hC0, 8'h00, 5'b00000, 2'd2, 8'hC0, 8'h7F, 8'hC0, 8'h7F, 8'h40}, // R7
    '{8'hFF, 8'h00, 8'h0F, 5'b00001, 2'd3, 8'hFF, 8'h00, 8'h00, 8'h30, 8'h30}  // R4 R6 R7
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [7:0] samp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R10 reset state and read map
    reg_rd(2'd0, r); chk("R1 dir reset", r, 8'hFF);
    reg_rd(2'd1, r); chk("R1 lat reset", r, 8'h00);
    reg_rd(2'd3, r); chk("R1 ana reset", r, 8'h2F);
    chk("R1 oe reset", pin_oe, 8'h00);
    chk("R1 ie reset", pin_ie, 8'hD0);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      reg_wr(2'd0, VECS[v].dir);
      reg_wr(2'd1, VECS[v].lat);
      reg_wr(2'd3, VECS[v].ana);
      {cmp1_oe, cmp1_val, cmp2_oe, cmp2_val, vref_oe} = VECS[v].cfg;
      osc_mode = VECS[v].osc;
      pin_in   = VECS[v].pin;
      @(negedge clk); @(negedge clk);
      reg_rd(2'd2, r);
      chk($sformatf("VEC%0d oe", v), pin_oe, VECS[v].e_oe);
      chk($sformatf("VEC%0d out", v), pin_out & VECS[v].e_oe, VECS[v].e_out & VECS[v].e_oe);
      chk($sformatf("VEC%0d ie", v), pin_ie, VECS[v].e_ie);
      chk($sformatf("VEC%0d port", v), r, VECS[v].e_port);
    end
    {cmp1_oe, cmp1_val, cmp2_oe, cmp2_val, vref_oe} = '0;
    osc_mode = 2'd0;

    // R10 port-address write lands in latch, analog register writable
    reg_wr(2'd2, 8'h3C);
    reg_rd(2'd1, r); chk("R10 latch via port addr", r, 8'h3C);
    reg_wr(2'd3, 8'h81);
    reg_rd(2'd3, r); chk("R10 analog readback", r, 8'h81);

    // R2 latch drives when direction is output
    reg_wr(2'd3, 8'h00);
    reg_wr(2'd0, 8'h00);
    reg_wr(2'd1, 8'h5A);
    chk("R2 out", pin_out, 8'h5A);
    chk("R2 oe", pin_oe, 8'hFF);

    // R4 analog keeps latch output but gates input
    reg_wr(2'd3, 8'hFF);
    chk("R4 out kept", pin_out, 8'h5A);
    chk("R4 ie off", pin_ie, 8'h00);

    // R3 synchronizer latency
    reg_wr(2'd3, 8'h00);
    reg_wr(2'd0, 8'hFF);
    pin_in = 8'h00;
    @(negedge clk); @(negedge clk);
    pin_in = 8'hA6;
    @(negedge clk);
    reg_rd(2'd2, r); chk("R3 one edge", r, 8'h00);
    @(negedge clk);
    reg_rd(2'd2, r); chk("R3 two edges", r, 8'hA6);

    // R5 comparator ignored while pin is input
    cmp2_oe = 1'b1; cmp2_val = 1'b1;
    #1; chk("R5 input not driven", pin_oe & 8'h20, 8'h00);
    cmp2_oe = 1'b0; cmp2_val = 1'b0;

    // R6 reference output beats direction 0
    reg_wr(2'd0, 8'h00);
    vref_oe = 1'b1;
    #1; chk("R6 oe pin2", pin_oe & 8'h04, 8'h00);
    vref_oe = 1'b0;

    // R8 clock output on pin 6
    osc_mode = 2'd1;
    reg_wr(2'd0, 8'hFF);
    chk("R8 oe6", pin_oe & 8'h40, 8'h40);
    chk("R8 ie6", pin_ie & 8'h40, 8'h00);
    for (int k = 0; k < 8; k++) begin
      samp = {samp[6:0], pin_out[6]};
      @(negedge clk);
    end
    chk("R8 two-cycle levels", {samp[7] ^ samp[5], samp[6] ^ samp[4], samp[3] ^ samp[1], samp[2] ^ samp[0]}, 4'hF);
    chk("R8 duty", 8'($countones(samp[3:0])), 8'd2);
    osc_mode = 2'd0;

    // R7 mode 2 leaves pin 6 free
    osc_mode = 2'd2;
    reg_wr(2'd0, 8'h00);
    chk("R7 mode2 oe", pin_oe & 8'hC0, 8'h40);
    osc_mode = 2'd0;

    // R9 timer clock from pin 4
    reg_wr(2'd0, 8'hFF);
    pin_in = 8'h10;
    @(negedge clk); @(negedge clk);
    chk("R9 tmr high", {7'd0, tmr_clk}, 8'd1);
    reg_wr(2'd3, 8'h10);
    chk("R9 tmr gated", {7'd0, tmr_clk}, 8'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule